// File: doc/BRIEF.md
# Timer Compare Output Unit

This block watches two free-running 16-bit timers and a 16-bit compare register. A select input chooses which timer is checked against the register. When the chosen timer count becomes equal to the register, the block raises one match event. A 4-bit mode input then decides what the event does. It can drive an output latch high, drive it low, toggle it, or only raise an interrupt flag. It can also issue a special trigger that returns the chosen timer to zero.

In the trigger mode, the compare register sets the period of the chosen timer. The trigger can also issue a one-cycle request to start an external conversion. The two timers are part of the block. Each timer has an enable, wraps around, and keeps a sticky overflow flag. A wrap sets that flag. A trigger-driven return to zero does not.

Top module: `tcu_compare_unit`

## Requirements
- R1: Each timer counts up by one on every clock where its bit of `tmr_en` is high, and holds otherwise. Going from 0xFFFF to 0x0000 sets that timer's sticky `ovf_flag` bit. A high `ovf_clr` bit clears the flag, but a wrap in the same cycle keeps it set.
- R2: `tmr_sel` = 0 compares timer 0 (`tmr_count[15:0]`) and `tmr_sel` = 1 compares timer 1 (`tmr_count[31:16]`). The other timer is ignored.
- R3: A match event occurs only on the cycle where equality becomes true. If equality stays true for several cycles, for example while the timer is stalled, no further event occurs.
- R4: With mode 4'b1000, the cycle after a match drives `cmp_out` to 1.
- R5: With mode 4'b1001, the cycle after a match drives `cmp_out` to 0.
- R6: With mode 4'b0010, the cycle after a match inverts `cmp_out`.
- R7: With mode 4'b1010, a match leaves `cmp_out` unchanged and still sets `irq_flag`.
- R8: In modes 1000, 1001, 0010, 1010 and 1011, every match sets `irq_flag` on the next cycle. The flag stays set until `irq_clr` is high. If a clear and a match fall in the same cycle, the flag stays set.
- R9: With mode 4'b1011, `evt_trig` is high for exactly the match cycle, and on the next cycle the selected timer reads zero. With the selected timer enabled, the timer therefore repeats every compare value + 1 cycles.
- R10: A return to zero caused by `evt_trig` never sets that timer's `ovf_flag`.
- R11: `conv_start` is high exactly when `evt_trig` is high and `conv_en` is high.
- R12: Mode 4'b0000, and every value not listed above, drives `cmp_out` to 0 on the next cycle. In these modes a match sets no flag and raises no trigger.
- R13: A high `cmp_load` writes `cmp_data` into the compare register at the clock edge, and the new value is used from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_load | input | 1 | Write strobe for the compare register |
| cmp_data | input | 16 | Value for the compare register |
| mode | input | 4 | Match action selector |
| tmr_sel | input | 1 | Chooses the timer that is compared |
| tmr_en | input | 2 | Per-timer count enable |
| ovf_clr | input | 2 | Per-timer overflow flag clear |
| irq_clr | input | 1 | Clears the compare interrupt flag |
| conv_en | input | 1 | Allows the conversion request on a trigger |
| tmr_count | output | 32 | Timer 1 count in the upper half, timer 0 count in the lower half |
| ovf_flag | output | 2 | Sticky wrap flags, one per timer |
| cmp_out | output | 1 | Compare output latch |
| irq_flag | output | 1 | Sticky compare interrupt flag |
| evt_trig | output | 1 | Special trigger pulse |
| conv_start | output | 1 | One-cycle conversion start request |

## Verification
The bench stalls a timer on the compare value. A design that used level matching would keep toggling or re-flagging there. The bench also raises a clear in the exact match cycle, which exposes a flag with the wrong priority. It runs both timers through a full wrap and then forces a trigger reset. A design that treated the forced zero as a wrap would raise a false overflow, and a wrong period shows up as a misplaced zero. Undefined mode codes and the interrupt-only mode are driven through real matches. A decoder that fell through to a pin action would move `cmp_out` or set the flag.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  localparam logic [3:0] MODE_OFF = 4'b0000;
  localparam logic [3:0] MODE_SET = 4'b1000;
  localparam logic [3:0] MODE_CLR = 4'b1001;
  localparam logic [3:0] MODE_TOG = 4'b0010;
  localparam logic [3:0] MODE_IRQ = 4'b1010;
  localparam logic [3:0] MODE_SPC = 4'b1011;

  typedef enum logic [2:0] {
    ACT_OFF,
    ACT_SET,
    ACT_CLR,
    ACT_TOG,
    ACT_IRQ,
    ACT_SPC
  } act_e;

  // Map the raw mode code to an action; unknown codes behave as off.
  function automatic act_e decode_mode(input logic [3:0] code);
    case (code)
      MODE_SET: return ACT_SET;
      MODE_CLR: return ACT_CLR;
      MODE_TOG: return ACT_TOG;
      MODE_IRQ: return ACT_IRQ;
      MODE_SPC: return ACT_SPC;
      default:  return ACT_OFF;
    endcase
  endfunction

  // Next value of the output latch for a given action.
  function automatic logic next_latch(input act_e act, input logic cur, input logic hit);
    case (act)
      ACT_OFF: return 1'b0;
      ACT_SET: return hit ? 1'b1 : cur;
      ACT_CLR: return hit ? 1'b0 : cur;
      ACT_TOG: return hit ? ~cur : cur;
      default: return cur;
    endcase
  endfunction

  // True for every code whose match raises the interrupt flag.
  function automatic logic mode_active(input logic [3:0] code);
    return decode_mode(code) != ACT_OFF;
  endfunction

endpackage

// File: rtl/tcu_timer.sv
module tcu_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          sync_zero,
  input  logic          flag_clr,
  output logic [TW-1:0] count,
  output logic          ovf
);

  logic wrap_evt;

  // The forced return to zero wins over counting and is never a wrap.
  assign wrap_evt = inc && !sync_zero && (count == {TW{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (sync_zero) begin
      count <= '0;
    end else if (inc) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf <= 1'b0;
    end else if (wrap_evt) begin
      ovf <= 1'b1;
    end else if (flag_clr) begin
      ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/tcu_match.sv
module tcu_match #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cmp_val,
  input  logic [TW-1:0] cnt_val,
  output logic          match_evt
);

  logic eq_now;
  logic eq_q;

  assign eq_now = (cnt_val == cmp_val);

  // Remember the previous equality so only a fresh match fires.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eq_q <= 1'b1;
    end else begin
      eq_q <= eq_now;
    end
  end

  assign match_evt = eq_now && !eq_q;

endmodule

// File: rtl/tcu_action.sv
module tcu_action
  import tcu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  act_e act,
  input  logic match_evt,
  input  logic irq_clr,
  input  logic conv_en,
  output logic cmp_out,
  output logic irq_flag,
  output logic evt_trig,
  output logic conv_start
);

  logic irq_set;

  assign irq_set    = match_evt && (act != ACT_OFF);
  assign evt_trig   = match_evt && (act == ACT_SPC);
  assign conv_start = evt_trig && conv_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_out <= 1'b0;
    end else begin
      cmp_out <= next_latch(act, cmp_out, match_evt);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
    end else if (irq_set) begin
      irq_flag <= 1'b1;
    end else if (irq_clr) begin
      irq_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/tcu_compare_unit.sv
module tcu_compare_unit
  import tcu_pkg::*;
#(
  parameter int TW      = 16,
  parameter int NUM_TMR = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmp_load,
  input  logic [TW-1:0]         cmp_data,
  input  logic [3:0]            mode,
  input  logic [SELW-1:0]       tmr_sel,
  input  logic [NUM_TMR-1:0]    tmr_en,
  input  logic [NUM_TMR-1:0]    ovf_clr,
  input  logic                  irq_clr,
  input  logic                  conv_en,
  output logic [NUM_TMR*TW-1:0] tmr_count,
  output logic [NUM_TMR-1:0]    ovf_flag,
  output logic                  cmp_out,
  output logic                  irq_flag,
  output logic                  evt_trig,
  output logic                  conv_start
);

  localparam int SELW = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

  logic [TW-1:0]      cmp_reg;
  logic [TW-1:0]      sel_count;
  logic [NUM_TMR-1:0] trig_zero;
  logic               match_evt;
  act_e               act;

  assign act = decode_mode(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_reg <= '0;
    end else if (cmp_load) begin
      cmp_reg <= cmp_data;
    end
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign trig_zero[t] = evt_trig && (tmr_sel == SELW'(t));
    tcu_timer #(.TW(TW)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (tmr_en[t]),
      .sync_zero (trig_zero[t]),
      .flag_clr  (ovf_clr[t]),
      .count     (tmr_count[t*TW +: TW]),
      .ovf       (ovf_flag[t])
    );
  end

  always_comb begin
    sel_count = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (tmr_sel == SELW'(i)) sel_count = tmr_count[i*TW +: TW];
    end
  end

  tcu_match #(.TW(TW)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_val   (cmp_reg),
    .cnt_val   (sel_count),
    .match_evt (match_evt)
  );

  tcu_action u_act (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .match_evt  (match_evt),
    .irq_clr    (irq_clr),
    .conv_en    (conv_en),
    .cmp_out    (cmp_out),
    .irq_flag   (irq_flag),
    .evt_trig   (evt_trig),
    .conv_start (conv_start)
  );

endmodule

// File: rtl/tcu_compare_checker.sv
module tcu_compare_checker
  import tcu_pkg::*;
#(
  parameter int TW      = 16,
  parameter int NUM_TMR = 2,
  parameter int SELW    = 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [3:0]            mode,
  input logic [SELW-1:0]       tmr_sel,
  input logic                  conv_en,
  input logic                  match_evt,
  input logic [NUM_TMR*TW-1:0] tmr_count,
  input logic [NUM_TMR-1:0]    ovf_flag,
  input logic                  cmp_out,
  input logic                  irq_flag,
  input logic                  evt_trig,
  input logic                  conv_start
);

  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> !match_evt);

  assert_set_drives_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode == MODE_SET) |=> cmp_out);

  assert_clr_drives_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode == MODE_CLR) |=> !cmp_out);

  assert_toggle_inverts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode == MODE_TOG) |=> (cmp_out != $past(cmp_out)));

  assert_irq_only_keeps_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode == MODE_IRQ) |=> ($stable(cmp_out) && irq_flag));

  assert_match_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode_active(mode)) |=> irq_flag);

  assert_trig_on_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_trig |-> (match_evt && mode == MODE_SPC));

  assert_conv_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (evt_trig && conv_en));

  assert_off_forces_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_active(mode) |=> !cmp_out);

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
    assert_trig_zeroes_timer_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_trig && tmr_sel == SELW'(t)) |=> (tmr_count[t*TW +: TW] == '0));

    assert_trig_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_trig && tmr_sel == SELW'(t) && !ovf_flag[t]) |=> !ovf_flag[t]);
  end

endmodule

bind tcu_compare_unit tcu_compare_checker #(
  .TW      (TW),
  .NUM_TMR (NUM_TMR),
  .SELW    (SELW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .tmr_sel    (tmr_sel),
  .conv_en    (conv_en),
  .match_evt  (match_evt),
  .tmr_count  (tmr_count),
  .ovf_flag   (ovf_flag),
  .cmp_out    (cmp_out),
  .irq_flag   (irq_flag),
  .evt_trig   (evt_trig),
  .conv_start (conv_start)
);

// File: tb/tcu_compare_unit_test.sv
module tcu_compare_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_load;
  logic [15:0] cmp_data;
  logic [3:0]  mode;
  logic [0:0]  tmr_sel;
  logic [1:0]  tmr_en;
  logic [1:0]  ovf_clr;
  logic        irq_clr;
  logic        conv_en;
  logic [31:0] tmr_count;
  logic [1:0]  ovf_flag;
  logic        cmp_out;
  logic        irq_flag;
  logic        evt_trig;
  logic        conv_start;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcu_compare_unit uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_load   (cmp_load),
    .cmp_data   (cmp_data),
    .mode       (mode),
    .tmr_sel    (tmr_sel),
    .tmr_en     (tmr_en),
    .ovf_clr    (ovf_clr),
    .irq_clr    (irq_clr),
    .conv_en    (conv_en),
    .tmr_count  (tmr_count),
    .ovf_flag   (ovf_flag),
    .cmp_out    (cmp_out),
    .irq_flag   (irq_flag),
    .evt_trig   (evt_trig),
    .conv_start (conv_start)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmp_load = 1'b0; cmp_data = '0; mode = 4'b0000;
    tmr_sel = 1'b0; tmr_en = 2'b00; ovf_clr = 2'b00; irq_clr = 1'b0;
    conv_en = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic load_cmp(input logic [15:0] v);
    cmp_load = 1'b1; cmp_data = v;
    step();
    cmp_load = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "count after reset", tmr_count, 32'h0);
    chk("R1", "ovf after reset", {30'h0, ovf_flag}, 32'h0);
    chk("R12", "cmp_out after reset", {31'h0, cmp_out}, 32'h0);
    chk("R8", "irq after reset", {31'h0, irq_flag}, 32'h0);
    chk("R9", "trig after reset", {30'h0, evt_trig, conv_start}, 32'h0);
  endtask

  task automatic t_set();
    do_reset();
    load_cmp(16'd5);
    mode = 4'b1000; tmr_en = 2'b01;
    step(4);
    chk("R4", "out before match", {31'h0, cmp_out}, 32'h0);
    step();
    chk("R1", "timer0 count", {16'h0, tmr_count[15:0]}, 32'd5);
    step();
    chk("R4", "out after match", {31'h0, cmp_out}, 32'h1);
    chk("R13", "loaded value matched", {31'h0, irq_flag}, 32'h1);
    chk("R1", "disabled timer1 holds", {16'h0, tmr_count[31:16]}, 32'h0);
  endtask

  task automatic t_clear();
    do_reset();
    load_cmp(16'd3);
    mode = 4'b1000; tmr_en = 2'b01;
    step(4);
    chk("R4", "out set", {31'h0, cmp_out}, 32'h1);
    tmr_en = 2'b00;
    load_cmp(16'd6);
    mode = 4'b1001; tmr_en = 2'b01;
    step(2);
    chk("R5", "out before clear match", {31'h0, cmp_out}, 32'h1);
    step();
    chk("R5", "out after clear match", {31'h0, cmp_out}, 32'h0);
  endtask

  task automatic t_toggle();
    do_reset();
    tmr_sel = 1'b1;
    load_cmp(16'd2);
    mode = 4'b0010; tmr_en = 2'b10;
    step(2);
    chk("R2", "timer1 count", {16'h0, tmr_count[31:16]}, 32'd2);
    chk("R6", "out before toggle", {31'h0, cmp_out}, 32'h0);
    step();
    chk("R6", "first toggle", {31'h0, cmp_out}, 32'h1);
    chk("R2", "timer0 unused", {16'h0, tmr_count[15:0]}, 32'h0);
    tmr_en = 2'b00;
    load_cmp(16'd4);
    tmr_en = 2'b10;
    step(2);
    chk("R6", "second toggle", {31'h0, cmp_out}, 32'h0);
  endtask

  task automatic t_hold();
    do_reset();
    load_cmp(16'd3);
    mode = 4'b0010; tmr_en = 2'b01;
    step(3);
    tmr_en = 2'b00;
    step();
    chk("R3", "toggle on match", {31'h0, cmp_out}, 32'h1);
    step(3);
    chk("R3", "no retoggle while stalled", {31'h0, cmp_out}, 32'h1);
    irq_clr = 1'b1;
    step();
    irq_clr = 1'b0;
    step(2);
    chk("R3", "no re-flag while stalled", {31'h0, irq_flag}, 32'h0);
  endtask

  task automatic t_irq();
    do_reset();
    load_cmp(16'd2);
    mode = 4'b1000; tmr_en = 2'b01;
    step(3);
    chk("R8", "flag set", {31'h0, irq_flag}, 32'h1);
    irq_clr = 1'b1;
    step();
    irq_clr = 1'b0;
    chk("R8", "flag cleared", {31'h0, irq_flag}, 32'h0);
    tmr_en = 2'b00;
    load_cmp(16'd5);
    mode = 4'b1010; tmr_en = 2'b01;
    step(2);
    chk("R7", "pin untouched", {31'h0, cmp_out}, 32'h1);
    chk("R7", "flag from irq mode", {31'h0, irq_flag}, 32'h1);
    tmr_en = 2'b00;
    load_cmp(16'd8);
    tmr_en = 2'b01;
    step(2);
    irq_clr = 1'b1;
    step();
    chk("R8", "set wins over clear", {31'h0, irq_flag}, 32'h1);
    step();
    irq_clr = 1'b0;
    chk("R8", "clear afterwards", {31'h0, irq_flag}, 32'h0);
  endtask

  task automatic t_special();
    do_reset();
    load_cmp(16'd4);
    mode = 4'b1011; conv_en = 1'b1; tmr_en = 2'b11;
    step(4);
    chk("R9", "trigger on match", {31'h0, evt_trig}, 32'h1);
    chk("R11", "conv with enable", {31'h0, conv_start}, 32'h1);
    step();
    chk("R9", "selected timer zeroed", {16'h0, tmr_count[15:0]}, 32'h0);
    chk("R9", "other timer runs", {16'h0, tmr_count[31:16]}, 32'd5);
    chk("R9", "trigger one cycle", {30'h0, evt_trig, conv_start}, 32'h0);
    chk("R10", "no overflow", {30'h0, ovf_flag}, 32'h0);
    step(4);
    conv_en = 1'b0;
    #1;
    chk("R9", "period repeats", {31'h0, evt_trig}, 32'h1);
    chk("R11", "conv gated off", {31'h0, conv_start}, 32'h0);
    step();
    chk("R9", "zero again", {16'h0, tmr_count[15:0]}, 32'h0);
  endtask

  task automatic t_off();
    do_reset();
    load_cmp(16'd2);
    mode = 4'b1000; tmr_en = 2'b01;
    step(3);
    mode = 4'b0000;
    step();
    chk("R12", "zero mode forces low", {31'h0, cmp_out}, 32'h0);
    irq_clr = 1'b1;
    step();
    irq_clr = 1'b0;
    tmr_en = 2'b00;
    load_cmp(16'd7);
    mode = 4'b0101; tmr_en = 2'b01;
    step(2);
    chk("R12", "no trigger in undefined mode", {31'h0, evt_trig}, 32'h0);
    step();
    chk("R12", "no flag in undefined mode", {31'h0, irq_flag}, 32'h0);
    chk("R12", "pin low in undefined mode", {31'h0, cmp_out}, 32'h0);
  endtask

  task automatic t_wrap();
    do_reset();
    tmr_en = 2'b11;
    step(65535);
    chk("R1", "both at max", tmr_count, 32'hFFFF_FFFF);
    chk("R1", "no flag before wrap", {30'h0, ovf_flag}, 32'h0);
    step();
    chk("R1", "wrapped", tmr_count, 32'h0);
    chk("R1", "flags after wrap", {30'h0, ovf_flag}, 32'h3);
    ovf_clr = 2'b01;
    step();
    chk("R1", "clear timer0 flag", {30'h0, ovf_flag}, 32'h2);
    ovf_clr = 2'b10;
    step();
    ovf_clr = 2'b00;
    tmr_en = 2'b00;
    tmr_sel = 1'b1;
    load_cmp(16'd4);
    mode = 4'b1011;
    step(2);
    chk("R1", "disabled timers hold", tmr_count, 32'h0002_0002);
    tmr_en = 2'b10;
    step(2);
    chk("R9", "trigger on timer1", {31'h0, evt_trig}, 32'h1);
    step();
    chk("R10", "timer1 zeroed", {16'h0, tmr_count[31:16]}, 32'h0);
    chk("R10", "no flag from trigger", {30'h0, ovf_flag}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_set();
    t_clear();
    t_toggle();
    t_hold();
    t_irq();
    t_special();
    t_off();
    t_wrap();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule